// File: doc/BRIEF.md
# Dual-Form Operand Forwarding Selector

This block decides, for each of the two source operands of the instruction now in the execute stage, where that operand's value should come from. Arithmetic results leave execute in a redundant signed-digit form and become signed-magnitude only during the memory stage. A value still in the memory stage therefore exists in two forms at once, and the right form depends on the consumer. An arithmetic consumer needs the untranslated digits because it cannot wait for translation. A logical or address-generating consumer needs the translated binary value.

The block compares each source register number with the destination registers held in the memory-stage and writeback-stage pipeline registers. It weighs the kind of result in the memory stage and the class of the consumer, and emits a three-bit select code per operand. It also drives the one-hot steering for the three-way writeback selector, which chooses among the logical result, the translated arithmetic result and the loaded data. The block is purely combinational. The clock and reset serve only its embedded checks.

Top module: `fwd_dual_form`

## Requirements
- R1: An operand whose register matches neither the memory-stage nor the writeback-stage destination gets select code 0 (register file).
- R2: A source register number of 0 always gets select code 0, whatever the destinations.
- R3: A memory-stage arithmetic result (result kind 0) feeding an arithmetic consumer (class 0) gets code 1: untranslated signed-digit value.
- R4: A memory-stage arithmetic result feeding a logical consumer (class 1) gets code 2: translated signed-magnitude value.
- R5: A memory-stage arithmetic result used as an address base (class 2) gets code 2: translated value.
- R6: A memory-stage logical result (kind 1) gets code 3 (as is) for logical and address consumers, and code 4 (re-encoded to signed-digit) for an arithmetic consumer.
- R7: The memory stage never forwards when its write enable is low or its result kind is 2 (load, data not yet available) or 3 (no result). Such an operand falls back to the writeback match or the register file.
- R8: When both stages match a forwardable result, the memory stage wins.
- R9: A writeback-stage match gets code 5 (signed-magnitude as is) for logical and address consumers, and code 6 (re-encoded to signed-digit) for an arithmetic consumer.
- R10: A consumer class of 3 (operand unused) gives code 0 on both operands.
- R11: Each operand's select depends only on its own source register. Operand A and operand B may receive different codes in the same cycle.
- R12: The writeback steering output is one-hot. Bit 0 selects the arithmetic result for writeback kind 0, bit 1 the logical result for kind 1, and bit 2 the loaded data for kind 2. It is all zero for kind 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks only |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| ex_src_a | input | REG_W | Source register of operand A in execute |
| ex_src_b | input | REG_W | Source register of operand B in execute |
| ex_use | input | 2 | Consumer class: 0 arithmetic, 1 logical, 2 address, 3 unused |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | REG_W | Memory-stage destination register |
| mem_kind | input | 2 | Memory-stage result kind: 0 arithmetic, 1 logical, 2 load, 3 none |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | REG_W | Writeback-stage destination register |
| wb_kind | input | 2 | Writeback-stage result kind, same encoding as mem_kind |
| sel_a | output | 3 | Select code for operand A (0..6 as in the requirements) |
| sel_b | output | 3 | Select code for operand B |
| wb_steer | output | 3 | One-hot writeback selector: bit0 arithmetic, bit1 logical, bit2 load |

## Verification
With a three-bit register number, the bench sweeps every combination of operand A's source, both destinations, both write enables, the memory result kind and the consumer class. This covers every match pattern: none, memory only, writeback only, both, and register 0. Operand B is held at a fixed bit-flip of operand A's source. Any case where the two operands share logic shows up as differing expected codes in the same cycle. Sweeping the memory kind through load and none separates the fall-back to writeback from true memory forwarding. Sweeping the consumer class over all four values separates the untranslated, translated and re-encoded forms. The writeback kind is swept alongside to check the one-hot steering.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    USE_ARITH = 2'd0,
    USE_LOGIC = 2'd1,
    USE_ADDR  = 2'd2,
    USE_NONE  = 2'd3
  } use_e;

  typedef enum logic [1:0] {
    RES_ARITH = 2'd0,
    RES_LOGIC = 2'd1,
    RES_LOAD  = 2'd2,
    RES_NONE  = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    SEL_RF          = 3'd0,
    SEL_MEM_SD      = 3'd1,
    SEL_MEM_SM      = 3'd2,
    SEL_MEM_LOG     = 3'd3,
    SEL_MEM_LOG_ENC = 3'd4,
    SEL_WB_SM       = 3'd5,
    SEL_WB_ENC      = 3'd6
  } sel_e;

  localparam int unsigned SEL_W   = 3;
  localparam int unsigned STEER_W = 3;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_dst,
  input  logic [1:0]       mem_kind,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_dst,
  output logic             hit_mem,
  output logic             hit_wb
);
  import fwd_pkg::*;

  logic src_live;
  logic mem_ready;

  always_comb begin
    src_live  = (src != '0);
    mem_ready = mem_wen && ((mem_kind == RES_ARITH) || (mem_kind == RES_LOGIC));
    hit_mem   = src_live && mem_ready && (src == mem_dst);
    hit_wb    = src_live && wb_wen && (src == wb_dst);
  end

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] use_cls,
  input  logic [1:0] mem_kind,
  input  logic       hit_mem,
  input  logic       hit_wb,
  output logic [2:0] sel
);
  import fwd_pkg::*;

  logic wants_digits;

  always_comb begin
    wants_digits = (use_cls == USE_ARITH);
    sel = SEL_RF;
    if (use_cls != USE_NONE) begin
      if (hit_mem) begin
        if (mem_kind == RES_ARITH)
          sel = wants_digits ? SEL_MEM_SD : SEL_MEM_SM;
        else
          sel = wants_digits ? SEL_MEM_LOG_ENC : SEL_MEM_LOG;
      end else if (hit_wb) begin
        sel = wants_digits ? SEL_WB_ENC : SEL_WB_SM;
      end
    end
  end

  // R3: untranslated digits go only to arithmetic consumers
  p_digits_to_arith_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_MEM_SD) |-> (use_cls == USE_ARITH));

  // R4, R5: translated arithmetic result never reaches an arithmetic consumer
  p_translated_not_arith_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_mem && mem_kind == RES_ARITH && use_cls != USE_ARITH && use_cls != USE_NONE)
      |-> (sel == SEL_MEM_SM));

  // R9: writeback forms follow the consumer class
  p_wb_form_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_mem && hit_wb && use_cls == USE_ARITH) |-> (sel == SEL_WB_ENC));

  // R10: unused operand never forwards
  p_unused_rf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (use_cls == USE_NONE) |-> (sel == SEL_RF));

endmodule

// File: rtl/wb_steer.sv
module wb_steer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wb_kind,
  output logic [2:0] steer
);
  import fwd_pkg::*;

  always_comb begin
    steer = '0;
    unique case (wb_kind)
      RES_ARITH: steer[0] = 1'b1;
      RES_LOGIC: steer[1] = 1'b1;
      RES_LOAD:  steer[2] = 1'b1;
      default:   steer = '0;
    endcase
  end

  // R12: at most one source drives the writeback bus
  p_steer_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(steer));

  p_steer_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_kind == RES_NONE) |-> (steer == '0));

endmodule

// File: rtl/fwd_dual_form.sv
module fwd_dual_form #(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [1:0]       ex_use,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_dst,
  input  logic [1:0]       mem_kind,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_dst,
  input  logic [1:0]       wb_kind,
  output logic [2:0]       sel_a,
  output logic [2:0]       sel_b,
  output logic [2:0]       wb_steer
);
  import fwd_pkg::*;

  localparam int unsigned N_OPS = 2;

  logic [REG_W-1:0] src   [N_OPS];
  logic [2:0]       sel_v [N_OPS];
  logic             h_mem [N_OPS];
  logic             h_wb  [N_OPS];

  assign src[0] = ex_src_a;
  assign src[1] = ex_src_b;

  for (genvar op = 0; op < N_OPS; op++) begin : g_op
    fwd_match #(.REG_W(REG_W)) match_i (
      .src      (src[op]),
      .mem_wen  (mem_wen),
      .mem_dst  (mem_dst),
      .mem_kind (mem_kind),
      .wb_wen   (wb_wen),
      .wb_dst   (wb_dst),
      .hit_mem  (h_mem[op]),
      .hit_wb   (h_wb[op])
    );

    fwd_pick pick_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .use_cls  (ex_use),
      .mem_kind (mem_kind),
      .hit_mem  (h_mem[op]),
      .hit_wb   (h_wb[op]),
      .sel      (sel_v[op])
    );

    // R2: register 0 never takes a forwarded value
    p_zero_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (src[op] == '0) |-> (sel_v[op] == SEL_RF));

    // R8: memory-stage match outranks writeback match
    p_mem_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (h_mem[op] && ex_use != USE_NONE) |->
        (sel_v[op] != SEL_WB_SM && sel_v[op] != SEL_WB_ENC && sel_v[op] != SEL_RF));

    // R7: loads in the memory stage are never sourced from there
    p_no_load_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_kind == RES_LOAD || mem_kind == RES_NONE || !mem_wen) |->
        (sel_v[op] inside {SEL_RF, SEL_WB_SM, SEL_WB_ENC}));
  end

  assign sel_a = sel_v[0];
  assign sel_b = sel_v[1];

  wb_steer steer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wb_kind (wb_kind),
    .steer   (wb_steer)
  );

endmodule

// File: tb/fwd_dual_form_tb_top.sv
module fwd_dual_form_tb_top;

  localparam int unsigned RW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] ex_src_a = '0;
  logic [RW-1:0] ex_src_b = '0;
  logic [1:0]    ex_use = '0;
  logic          mem_wen = 1'b0;
  logic [RW-1:0] mem_dst = '0;
  logic [1:0]    mem_kind = 2'd3;
  logic          wb_wen = 1'b0;
  logic [RW-1:0] wb_dst = '0;
  logic [1:0]    wb_kind = 2'd3;
  logic [2:0]    sel_a, sel_b, wb_steer;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fwd_dual_form #(.REG_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_use(ex_use),
    .mem_wen(mem_wen), .mem_dst(mem_dst), .mem_kind(mem_kind),
    .wb_wen(wb_wen), .wb_dst(wb_dst), .wb_kind(wb_kind),
    .sel_a(sel_a), .sel_b(sel_b), .wb_steer(wb_steer)
  );

  // Expected code from the requirement text (R1..R10)
  function automatic logic [2:0] expect_sel(input logic [RW-1:0] s);
    bit mhit, whit;
    if (ex_use == 2'd3) return 3'd0;                       // R10
    if (s == 0) return 3'd0;                               // R2
    mhit = mem_wen && (mem_kind <= 2'd1) && (s == mem_dst); // R7
    whit = wb_wen && (s == wb_dst);
    if (mhit) begin                                        // R8
      if (mem_kind == 2'd0) return (ex_use == 2'd0) ? 3'd1 : 3'd2; // R3 R4 R5
      return (ex_use == 2'd0) ? 3'd4 : 3'd3;               // R6
    end
    if (whit) return (ex_use == 2'd0) ? 3'd6 : 3'd5;       // R9
    return 3'd0;                                           // R1
  endfunction

  function automatic logic [2:0] expect_steer(input logic [1:0] k);
    return (k == 2'd3) ? 3'b000 : (3'b001 << k);           // R12
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (use=%0d mk=%0d me=%0d md=%0d we=%0d wd=%0d)",
               req, act, exp, ex_use, mem_kind, mem_wen, mem_dst, wb_wen, wb_dst);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    // Reset state with idle inputs: R1 and R12
    check("R1 reset sel_a", sel_a, 3'd0);
    check("R1 reset sel_b", sel_b, 3'd0);
    check("R12 reset steer", wb_steer, 3'b000);

    for (int u = 0; u < 4; u++)
      for (int mk = 0; mk < 4; mk++)
        for (int me = 0; me < 2; me++)
          for (int we = 0; we < 2; we++)
            for (int sa = 0; sa < (1 << RW); sa++)
              for (int md = 0; md < (1 << RW); md++)
                for (int wd = 0; wd < (1 << RW); wd++) begin
                  @(negedge clk);
                  ex_use   = u[1:0];
                  mem_kind = mk[1:0];
                  mem_wen  = me[0];
                  wb_wen   = we[0];
                  ex_src_a = sa[RW-1:0];
                  ex_src_b = sa[RW-1:0] ^ 3'b101;  // R11: differing operand
                  mem_dst  = md[RW-1:0];
                  wb_dst   = wd[RW-1:0];
                  wb_kind  = 2'(md + wd);
                  #5;
                  check("R3-R9 sel_a", sel_a, expect_sel(ex_src_a));
                  check("R11 sel_b", sel_b, expect_sel(ex_src_b));
                  check("R12 steer", wb_steer, expect_steer(wb_kind));
                end

    // Directed corners
    @(negedge clk);
    ex_use = 2'd0; mem_wen = 1'b1; mem_kind = 2'd0; mem_dst = 3'd2;
    wb_wen = 1'b1; wb_dst = 3'd2; ex_src_a = 3'd2; ex_src_b = 3'd0;
    #5;
    check("R8 mem over wb", sel_a, 3'd1);
    check("R2 zero src", sel_b, 3'd0);
    @(negedge clk);
    mem_kind = 2'd2;
    #5;
    check("R7 load falls to wb", sel_a, 3'd6);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule